// File: doc/BRIEF.md
# 16-bit Timer PWM Generator

This block is a 16-bit counter that drives one output pin as a pulse-width modulated waveform. Software programs two compare values: a duty point and a period point. When the counter reaches the duty point, the pin takes one programmable level. When it reaches the period point, the pin takes a second level, and the counter restarts from the fixed value 0xFFFC instead of zero. One waveform period therefore lasts the period compare value plus five counter ticks. The counter advances on a tick. That tick is the system clock divided by 2, 4 or 8, or a synchronized rising edge of an external clock pin.

The period match sets a capture-class status flag (bit 0), and that flag can raise an interrupt. The two compare-class flags stay clear while PWM mode runs. A capture pin stays usable in this mode: it latches the counter and sets its own flag. With PWM mode off, the counter runs freely and compare matches set the compare flags. Software clears a flag in two reads: it reads the status register, then it reads the register associated with that flag.

Registers use a 3-bit address and 16-bit data. Address 0 is control, 1 is the duty compare, 2 is the period compare, 3 is status (read only), 4 is the captured value (read only) and 5 is the counter (read only). The control bits are: [0] PWM enable, [1] one-pulse enable, [2] level driven at a duty match, [3] level driven at a period match, [5:4] clock select, [6] interrupt enable.

Top module: `pwm_timer16`

## Requirements
- R1: Clock select value 0 makes the counter tick every 2 system cycles, value 1 every 4 and value 2 every 8. One PWM period lasts (P+5)×div system cycles, where P is the period compare value.
- R2: Clock select value 3 makes the counter advance exactly once for each rising edge of `ext_clk`, after a two-flop synchronizer. It does not advance when the pin is idle.
- R3: After reset, every register is 0, the counter is 0xFFFC and the pin is 0. A control write that turns PWM enable from 0 to 1 loads the counter with 0xFFFC and drives the pin to the period-match level.
- R4: In PWM mode, a tick while the counter equals the period compare reloads the counter to 0xFFFC and drives the pin to the period-match level. This wins over a duty match when both compare values are equal.
- R5: In PWM mode, a tick while the counter equals the duty compare drives the pin to the duty-match level. That level lasts (P−D)×div system cycles, and the other level lasts (D+5)×div.
- R6: When both level bits are equal, the pin holds that level at all times in PWM mode.
- R7: The period match in PWM mode sets status bit 0.
- R8: `irq` is registered. It equals interrupt enable AND NOT `irq_mask` AND (status bit 0 OR status bit 1), and it follows one cycle after its inputs.
- R9: In PWM mode, the compare flags (status bits 2 and 3) are never set. With PWM off, the counter free-runs, the pin holds its level, and ticks at the duty or period compare value set bit 2 or bit 3.
- R10: A rising edge on `cap_in` (two-flop synchronized) copies the counter into the capture register and sets status bit 1. This works in both modes.
- R11: When one-pulse enable and PWM enable are both set, the waveform is the same as with PWM enable alone.
- R12: A flag clears only when its associated register is read (bit 0: address 2, bit 1: address 4, bit 2: address 1, bit 3: address 2) after a status read that saw the flag set. Reading the associated register without that status read leaves the flag set. A hardware set in the same cycle as the clearing read keeps the flag set.
- R13: Writes take effect on the clock edge where `wr_en` is sampled. Read data appears on `rd_data` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| ext_clk | input | 1 | External counter clock |
| cap_in | input | 1 | Capture trigger pin |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks `irq` |
| pwm_out | output | 1 | PWM output pin |
| flags | output | 4 | Status flags: period, capture, duty compare, period compare |
| irq | output | 1 | Interrupt request |

## Verification
The capture flag can be set by hardware in the same cycle that software performs the read that would clear it. The bench arms the flag with a status read. It then raises `cap_in` so that the synchronized edge reaches the flag register on exactly the edge where a read of address 4 is sampled. It counts the two synchronizer stages and the edge stage to find that edge. After the collision, the flag must still read as set, and a further plain read must still leave it set. A proper status read followed by a read of address 4 must then clear it.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    CLK_DIV2 = 2'd0,
    CLK_DIV4 = 2'd1,
    CLK_DIV8 = 2'd2,
    CLK_EXT  = 2'd3
  } clk_sel_e;

  typedef struct packed {
    logic     irq_en;
    clk_sel_e clk_sel;
    logic     lvl_period;
    logic     lvl_duty;
    logic     one_pulse;
    logic     pwm_on;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int NFLAG  = 4;

  localparam int FLG_PERIOD = 0;
  localparam int FLG_CAPT   = 1;
  localparam int FLG_CMPD   = 2;
  localparam int FLG_CMPP   = 3;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_DUTY   = 3'd1;
  localparam logic [2:0] A_PERIOD = 3'd2;
  localparam logic [2:0] A_STAT   = 3'd3;
  localparam logic [2:0] A_CAPT   = 3'd4;
  localparam logic [2:0] A_COUNT  = 3'd5;
endpackage

// File: rtl/ptm_edge_sync.sv
module ptm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/ptm_tick_gen.sv
module ptm_tick_gen
  import ptm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel,
  input  logic     ext_clk,
  output logic     tick
);
  logic [PRE_W-1:0] pre_q;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  ptm_edge_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
    .clk (clk),
    .rst (rst),
    .din (ext_clk),
    .rise(ext_rise)
  );

  always_comb begin
    case (sel)
      CLK_DIV2: tick = pre_q[0];
      CLK_DIV4: tick = &pre_q[1:0];
      CLK_DIV8: tick = &pre_q[2:0];
      default:  tick = ext_rise;
    endcase
  end
endmodule

// File: rtl/ptm_core.sv
module ptm_core #(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pwm_on,
  input  logic             pwm_start,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  input  logic             lvl_duty,
  input  logic             lvl_period,
  output logic [CNT_W-1:0] cnt,
  output logic             pin,
  output logic             per_hit,
  output logic             cmpd_hit,
  output logic             cmpp_hit
);
  logic eq_duty, eq_period;

  assign eq_duty   = (cnt == duty);
  assign eq_period = (cnt == period);
  assign per_hit   = tick & pwm_on & eq_period;
  assign cmpd_hit  = tick & ~pwm_on & eq_duty;
  assign cmpp_hit  = tick & ~pwm_on & eq_period;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RELOAD;
      pin <= 1'b0;
    end else if (pwm_start) begin
      cnt <= RELOAD;
      pin <= lvl_period;
    end else if (tick) begin
      if (pwm_on && eq_period) begin
        cnt <= RELOAD;
        pin <= lvl_period;
      end else begin
        cnt <= cnt + 1'b1;
        if (pwm_on && eq_duty) pin <= lvl_duty;
      end
    end
  end
endmodule

// File: rtl/ptm_flags.sv
module ptm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         stat_rd,
  input  logic [N-1:0] assoc_rd,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic arm_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q   <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        if (stat_rd)          arm_q <= flag[i];
        else if (assoc_rd[i]) arm_q <= 1'b0;

        if (set[i])                   flag[i] <= 1'b1;
        else if (assoc_rd[i] && arm_q) flag[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import ptm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_clk,
  input  logic             cap_in,
  input  logic             irq_mask,
  output logic             pwm_out,
  output logic [3:0]       flags,
  output logic             irq
);
  localparam logic [CNT_W-1:0] RELOAD = {{(CNT_W-2){1'b1}}, 2'b00};

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] duty_q, period_q, capt_q, cnt;
  logic             tick, pwm_start, per_hit, cmpd_hit, cmpp_hit, cap_hit;
  logic             stat_rd;
  logic [NFLAG-1:0] set_v, assoc_v, flag_v;
  logic             pwm_en_w, lvl_period_w;
  ctrl_t            ctrl_wr;

  assign ctrl_wr      = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign pwm_en_w     = ctrl_q.pwm_on;
  assign lvl_period_w = ctrl_q.lvl_period;
  assign pwm_start    = wr_en && (addr == A_CTRL) && ctrl_wr.pwm_on && !ctrl_q.pwm_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      duty_q   <= '0;
      period_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl_q   <= ctrl_wr;
        A_DUTY:   duty_q   <= wr_data;
        A_PERIOD: period_q <= wr_data;
        default:  ;
      endcase
    end
  end

  ptm_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .sel    (ctrl_q.clk_sel),
    .ext_clk(ext_clk),
    .tick   (tick)
  );

  ptm_core #(.CNT_W(CNT_W), .RELOAD(RELOAD)) core_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pwm_on    (ctrl_q.pwm_on),
    .pwm_start (pwm_start),
    .duty      (duty_q),
    .period    (period_q),
    .lvl_duty  (ctrl_q.lvl_duty),
    .lvl_period(ctrl_q.lvl_period),
    .cnt       (cnt),
    .pin       (pwm_out),
    .per_hit   (per_hit),
    .cmpd_hit  (cmpd_hit),
    .cmpp_hit  (cmpp_hit)
  );

  ptm_edge_sync #(.STAGES(SYNC_STAGES)) cap_sync_i (
    .clk (clk),
    .rst (rst),
    .din (cap_in),
    .rise(cap_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)          capt_q <= '0;
    else if (cap_hit) capt_q <= cnt;
  end

  assign stat_rd = rd_en && (addr == A_STAT);

  always_comb begin
    set_v             = '0;
    set_v[FLG_PERIOD] = per_hit;
    set_v[FLG_CAPT]   = cap_hit;
    set_v[FLG_CMPD]   = cmpd_hit;
    set_v[FLG_CMPP]   = cmpp_hit;
    assoc_v             = '0;
    assoc_v[FLG_PERIOD] = rd_en && (addr == A_PERIOD);
    assoc_v[FLG_CAPT]   = rd_en && (addr == A_CAPT);
    assoc_v[FLG_CMPD]   = rd_en && (addr == A_DUTY);
    assoc_v[FLG_CMPP]   = rd_en && (addr == A_PERIOD);
  end

  ptm_flags #(.N(NFLAG)) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set     (set_v),
    .stat_rd (stat_rd),
    .assoc_rd(assoc_v),
    .flag    (flag_v)
  );

  assign flags = flag_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= ctrl_q.irq_en & ~irq_mask & (flag_v[FLG_PERIOD] | flag_v[FLG_CAPT]);
      if (rd_en) begin
        case (addr)
          A_CTRL:   rd_data <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
          A_DUTY:   rd_data <= duty_q;
          A_PERIOD: rd_data <= period_q;
          A_STAT:   rd_data <= {{(CNT_W-NFLAG){1'b0}}, flag_v};
          A_CAPT:   rd_data <= capt_q;
          A_COUNT:  rd_data <= cnt;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             pwm_start,
  input logic             pwm_en,
  input logic             per_hit,
  input logic             cap_hit,
  input logic [CNT_W-1:0] cnt,
  input logic             pin,
  input logic             lvl_period,
  input logic [3:0]       flags,
  input logic             imask,
  input logic             irq
);
  localparam logic [CNT_W-1:0] RELOAD = {{(CNT_W-2){1'b1}}, 2'b00};

  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    per_hit |=> cnt == RELOAD); // R4
  AST_PERIOD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    per_hit |=> pin == $past(lvl_period)); // R4
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
    pwm_start |=> cnt == RELOAD); // R3
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pwm_start) |=> $stable(cnt)); // R2
  AST_PERIOD_FLAG: assert property (@(posedge clk) disable iff (rst)
    per_hit |=> flags[0]); // R7
  AST_CAPT_FLAG: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> flags[1]); // R10
  AST_NO_CMP_FLAG_PWM: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags[2]) || $rose(flags[3])) |-> !$past(pwm_en)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    imask |=> !irq); // R8
endmodule

bind pwm_timer16 pwm_timer16_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .pwm_start (pwm_start),
  .pwm_en    (pwm_en_w),
  .per_hit   (per_hit),
  .cap_hit   (cap_hit),
  .cnt       (cnt),
  .pin       (pwm_out),
  .lvl_period(lvl_period_w),
  .flags     (flags),
  .imask     (irq_mask),
  .irq       (irq)
);

// File: tb/pwm_timer16_tb_top.sv
module pwm_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ext_man = 1'b0, ext_auto = 1'b0, ext_run = 1'b0;
  logic        ext_clk;
  logic        cap_in = 1'b0, irq_mask = 1'b0;
  logic        pwm_out, irq;
  logic [3:0]  flags;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  assign ext_clk = ext_man | ext_auto;

  pwm_timer16 dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ext_clk(ext_clk), .cap_in(cap_in),
    .irq_mask(irq_mask), .pwm_out(pwm_out), .flags(flags), .irq(irq)
  );

  int ext_ph = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ext_ph = ext_ph + 1;
      if (ext_ph == 3) begin ext_auto <= ~ext_auto; ext_ph = 0; end
    end else begin
      ext_auto <= 1'b0; ext_ph = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(bit pwm, bit opm, bit ld, bit lp, bit [1:0] cs, bit ie);
    return {9'd0, ie, cs, lp, ld, opm, pwm};
  endfunction

  function automatic int div_of(bit [1:0] cs);
    case (cs) 2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 6; endcase
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_man = 1'b1; repeat (3) @(negedge clk);
      ext_man = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic cap_pulse();
    @(negedge clk); cap_in = 1'b1; repeat (4) @(negedge clk);
    cap_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo, output bit to);
    int t = 0;
    hi = 0; lo = 0;
    while (pwm_out !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    while (pwm_out !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    while (pwm_out === 1'b1 && t < 4000) begin @(negedge clk); t++; hi++; end
    while (pwm_out === 1'b0 && t < 4000) begin @(negedge clk); t++; lo++; end
    to = (t >= 4000);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int hi, lo;
    bit to;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: reset state
    check("R3 pin after reset", pwm_out, 0);
    check("R3 flags after reset", flags, 0);
    check("R8 irq after reset", irq, 0);
    rd(3'd5, d); check("R3 counter after reset", d, 16'hFFFC);
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'd3, 0));
    rd(3'd0, d); check("R13 control readback", d, 16'h0030);

    // R3: enabling PWM reloads, then leave it in free-run mode
    wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'd3, 0));
    rd(3'd5, d); check("R3 reload on enable", d, 16'hFFFC);
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'd3, 0));
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd4);
    rd(3'd5, d); check("R2 counter idle without ext edges", d, 16'hFFFC);

    // R9 free-run compare flags, R2 ext counting
    ext_pulses(7);
    rd(3'd5, d); check("R2 seven ext edges", d, 16'd3);
    check("R9 duty compare flag in free-run", flags[2], 1);
    check("R9 period compare flag not yet", flags[3], 0);
    check("R9 pin holds in free-run", pwm_out, 0);
    ext_pulses(2);
    check("R9 period compare flag in free-run", flags[3], 1);

    // R12 clearing rules
    rd(3'd2, d); check("R12 no clear without status read", flags[3], 1);
    rd(3'd3, d); check("R12 status shows compare flags", d[3:2], 2'b11);
    rd(3'd1, d); check("R12 duty flag cleared", flags[2], 0);
    check("R12 other flag untouched", flags[3], 1);
    rd(3'd3, d); rd(3'd2, d); check("R12 period compare flag cleared", flags[3], 0);

    // R10 capture in free-run mode
    cap_pulse();
    check("R10 capture flag", flags[1], 1);
    rd(3'd4, d); check("R10 captured value", d, 16'd5);
    check("R12 capture read alone keeps flag", flags[1], 1);

    // R8 interrupt
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'd3, 1));
    @(negedge clk); check("R8 irq from capture flag", irq, 1);
    irq_mask = 1'b1; repeat (2) @(negedge clk);
    check("R8 irq masked", irq, 0);
    irq_mask = 1'b0; repeat (2) @(negedge clk);
    check("R8 irq unmasked", irq, 1);

    // R12 collision: hardware set on the clearing read
    rd(3'd3, d);
    @(negedge clk); cap_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 3'd4;
    @(negedge clk); rd_en = 1'b0; cap_in = 1'b0;
    check("R12 set wins over clear", flags[1], 1);
    rd(3'd4, d); check("R12 arm consumed by collision", flags[1], 1);
    rd(3'd3, d); rd(3'd4, d); check("R12 capture flag cleared", flags[1], 0);
    repeat (2) @(negedge clk);
    check("R8 irq drops with flags", irq, 0);

    // PWM with ext edges: duty 1, period 2
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd2);
    wr(3'd0, mk_ctrl(1, 0, 1, 0, 2'd3, 1));
    check("R3 pin at period level on enable", pwm_out, 0);
    ext_pulses(5);
    check("R5 pin before duty match", pwm_out, 0);
    ext_pulses(1);
    check("R5 pin at duty level", pwm_out, 1);
    ext_pulses(1);
    check("R4 pin at period level", pwm_out, 0);
    check("R7 period flag", flags[0], 1);
    check("R9 no compare flags in PWM", flags[3:2], 0);
    check("R8 irq from period flag", irq, 1);
    rd(3'd5, d); check("R4 reload value", d, 16'hFFFC);
    cap_pulse();
    rd(3'd4, d); check("R10 capture in PWM mode", d, 16'hFFFC);
    check("R10 capture flag in PWM mode", flags[1], 1);

    // R4 equal compare values: period match wins
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd1);
    ext_pulses(6);
    check("R4 period wins over duty", pwm_out, 0);
    rd(3'd5, d); check("R4 reload on shared match", d, 16'hFFFC);

    // R1 R5 R11 random waveforms
    for (int it = 0; it < 8; it++) begin
      int dv, pv, dvd;
      bit [1:0] cs;
      bit opm;
      dv  = 1 + ($urandom % 20);
      pv  = dv + 1 + ($urandom % 30);
      cs  = 2'($urandom % 4);
      opm = 1'($urandom % 2);
      if (it == 0) begin cs = 2'd0; opm = 1'b1; end
      if (it == 1) cs = 2'd3;
      dvd = div_of(cs);
      wr(3'd0, mk_ctrl(0, 0, 1, 0, cs, 0));
      wr(3'd1, 16'(dv));
      wr(3'd2, 16'(pv));
      ext_run = (cs == 2'd3);
      wr(3'd0, mk_ctrl(1, opm, 1, 0, cs, 0));
      measure(hi, lo, to);
      ext_run = 1'b0;
      check(opm ? "R11 R5 duty-level time with one-pulse set" : "R5 duty-level time",
            hi, (pv - dv) * dvd);
      check(opm ? "R11 R1 period with one-pulse set" : "R1 period length",
            hi + lo, (pv + 5) * dvd);
    end

    // R6 equal levels
    wr(3'd0, mk_ctrl(0, 0, 1, 1, 2'd0, 0));
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd9);
    wr(3'd0, mk_ctrl(1, 0, 1, 1, 2'd0, 0));
    begin
      int lows = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (pwm_out !== 1'b1) lows++;
      end
      check("R6 constant pin with equal levels", lows, 0);
    end
    check("R7 period flag with equal levels", flags[0], 1);

    finish_run();
  end
endmodule